// File: doc/BRIEF.md
# Leading-one aligned unsigned divider

This block divides one 32-bit unsigned integer by another and returns the quotient and the remainder. When a request is accepted, two priority encoders find the index of the highest set bit in each operand. The divisor is shifted left by the difference between those indices, so its leading one sits under the dividend's leading one. The block then runs one compare-and-subtract step per clock, and only over that difference plus one. Leading-zero positions that could never produce a quotient bit are never visited.

A request is a one-cycle `start_i` with both operands valid. The block raises `busy_o` while it iterates and pulses `done_o` for one cycle when the result ports hold the answer. Results stay on the ports until the next accepted request. Three cases finish on the first clock without iterating: a zero divisor, a divisor larger than the dividend, and a zero dividend. A zero divisor is flagged rather than computed.

Top module: `lz_align_div`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all 0.
- R2: For a non-zero divisor, when `done_o` is high, `quotient_o` equals dividend / divisor and `remainder_o` equals dividend % divisor, both unsigned.
- R3: A zero divisor is reported at the first clock edge after the accepting edge: `done_o` = 1, `div_zero_o` = 1, `quotient_o` = 0xFFFFFFFF and `remainder_o` = dividend. `busy_o` stays 0.
- R4: If the divisor is non-zero and larger than the dividend (this includes a zero dividend), the result is reported at the first clock edge after the accepting edge with `quotient_o` = 0 and `remainder_o` = dividend. `busy_o` stays 0.
- R5: In all other cases, `busy_o` is high for exactly (msb(dividend) - msb(divisor) + 1) cycles after the accepting edge. `done_o` rises at the edge that ends the last of those cycles, and `busy_o` falls at that same edge.
- R6: `done_o` is high for exactly one cycle per accepted request and is never high together with `busy_o`.
- R7: A `start_i` seen while `busy_o` is high is ignored. The running division finishes with its own operands and on its own schedule.
- R8: `div_zero_o` is 0 on every completion with a non-zero divisor, including one that follows a divide-by-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse; taken only while `busy_o` is low |
| dividend_i | input | 32 | Dividend, sampled on the accepting edge |
| divisor_i | input | 32 | Divisor, sampled on the accepting edge |
| busy_o | output | 1 | High while subtraction steps run |
| done_o | output | 1 | One-cycle pulse: results are valid |
| quotient_o | output | 32 | Quotient |
| remainder_o | output | 32 | Remainder |
| div_zero_o | output | 1 | Set with `done_o` when the divisor was zero |

## Verification
Results are due one clock after the accepting edge for zero-divisor and divisor-larger cases. In every other case they are due after the accepting edge plus the leading-one distance plus one. The bench keeps a behavioural model that counts down that same latency, computed from its own leading-one search on the operands. At each falling edge the model's expected `busy_o` and `done_o` are compared with the ports. On the cycle the model marks as done, the quotient, remainder and flag are compared with the integer `/` and `%` operators. A late, early or repeated `done_o` is therefore reported on the exact cycle it goes wrong. A `start_i` raised mid-division is driven with conflicting operands, and the result that follows must still belong to the first request.

// File: rtl/lzd_pkg.sv
package lzd_pkg;
  localparam int unsigned LZD_W = 32;

  // how an accepted request is resolved
  typedef enum logic [1:0] {
    LZD_ITERATE  = 2'd0,
    LZD_ZERO_DIV = 2'd1,
    LZD_TRIVIAL  = 2'd2
  } lzd_kind_e;
endpackage

// File: rtl/lzd_msb_enc.sv
module lzd_msb_enc #(
  parameter int unsigned W  = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  // highest set bit wins: the later iteration overrides
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  // R5: the reported index is the leading one
  always_comb begin
    if (vec_i != '0) begin
      msb_hi_chk: assert ((vec_i >> idx_o) == W'(1));
    end
  end
endmodule

// File: rtl/lzd_step.sv
module lzd_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dsr_i,
  output logic         ge_o,
  output logic [W-1:0] rem_o
);
  function automatic logic [W-1:0] trial_sub(input logic [W-1:0] r,
                                             input logic [W-1:0] d,
                                             input logic         take);
    return take ? (r - d) : r;
  endfunction

  assign ge_o  = (rem_i >= dsr_i);
  assign rem_o = trial_sub(rem_i, dsr_i, ge_o);
endmodule

// File: rtl/lz_align_div.sv
module lz_align_div
  import lzd_pkg::*;
#(
  parameter int unsigned W = LZD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         div_zero_o
);
  localparam int unsigned IW = $clog2(W);
  localparam int unsigned CW = IW + 1;

  logic          busy_q, done_q, dbz_q;
  logic [W-1:0]  rem_q, dsr_q, quo_q;
  logic [CW-1:0] cnt_q;

  logic [IW-1:0] a_msb, b_msb, align_sh;
  logic          ge;
  logic [W-1:0]  rem_nx;
  logic          accept, last_step;
  lzd_kind_e     kind;

  function automatic lzd_kind_e classify(input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    if (b == '0)    return LZD_ZERO_DIV;
    else if (a < b) return LZD_TRIVIAL;
    else            return LZD_ITERATE;
  endfunction

  lzd_msb_enc #(.W(W)) u_enc_a (.vec_i(dividend_i), .idx_o(a_msb));
  lzd_msb_enc #(.W(W)) u_enc_b (.vec_i(divisor_i),  .idx_o(b_msb));

  lzd_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .dsr_i (dsr_q),
    .ge_o  (ge),
    .rem_o (rem_nx)
  );

  // named events for the checks below
  assign kind      = classify(dividend_i, divisor_i);
  assign align_sh  = a_msb - b_msb;
  assign accept    = start_i && !busy_q;
  assign last_step = busy_q && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dbz_q  <= 1'b0;
      rem_q  <= '0;
      dsr_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        rem_q <= dividend_i;
        dbz_q <= 1'b0;
        case (kind)
          LZD_ZERO_DIV: begin
            quo_q  <= '1;
            dbz_q  <= 1'b1;
            done_q <= 1'b1;
          end
          LZD_TRIVIAL: begin
            quo_q  <= '0;
            done_q <= 1'b1;
          end
          default: begin
            quo_q  <= '0;
            dsr_q  <= divisor_i << align_sh;
            cnt_q  <= CW'(align_sh) + CW'(1);
            busy_q <= 1'b1;
          end
        endcase
      end else if (busy_q) begin
        rem_q <= rem_nx;
        quo_q <= {quo_q[W-2:0], ge};
        dsr_q <= dsr_q >> 1;
        cnt_q <= cnt_q - CW'(1);
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign div_zero_o  = dbz_q;
  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R6
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_q && busy_q));
  // R5
  iter_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_step) |=> (busy_q && cnt_q == $past(cnt_q) - CW'(1)));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && !last_step) |=> (busy_q && !done_q));
  // R3
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == LZD_ZERO_DIV) |=> (done_q && dbz_q && (&quo_q) && !busy_q));
  // R4
  trivial_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == LZD_TRIVIAL) |=> (done_q && !dbz_q && quo_q == '0 && !busy_q));
  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && $past(busy_q)) |-> (rem_q < $past(dsr_q) && !dbz_q));
endmodule

// File: tb/sim_lz_align_div.sv
module sim_lz_align_div;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic        busy_o, done_o, div_zero_o;
  logic [31:0] quotient_o, remainder_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  // model state
  bit          m_busy = 1'b0;
  bit          m_done = 1'b0;
  int          m_left = 0;
  logic [31:0] e_q = '0, e_r = '0;
  bit          e_z = 1'b0;
  string       e_tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  lz_align_div u0 (
    .clk(clk), .rst(rst), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .div_zero_o(div_zero_o)
  );

  function automatic int lead_pos(input logic [31:0] v);
    int k = -1;
    while (v != 0) begin v = v >> 1; k++; end
    return k;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end else if (start_i) begin
        if (divisor_i == 0) begin
          m_done = 1; e_q = 32'hFFFF_FFFF; e_r = dividend_i; e_z = 1; e_tag = "R3";
        end else if (dividend_i < divisor_i) begin
          m_done = 1; e_q = 0; e_r = dividend_i; e_z = 0; e_tag = "R4";
        end else begin
          m_busy = 1;
          m_left = lead_pos(dividend_i) - lead_pos(divisor_i) + 1;
          e_q = dividend_i / divisor_i; e_r = dividend_i % divisor_i; e_z = 0; e_tag = "R2";
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 busy", {31'd0, busy_o}, {31'd0, m_busy});
      check("R6 done", {31'd0, done_o}, {31'd0, m_done});
      if (m_done) begin
        check({e_tag, " quotient"}, quotient_o, e_q);
        check({e_tag, " remainder"}, remainder_o, e_r);
        check(e_z ? "R3 flag" : "R8 flag", {31'd0, div_zero_o}, {31'd0, e_z});
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start_i = 1'b1; dividend_i = a; divisor_i = b;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done_o) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    check("R1 done", {31'd0, done_o}, 32'd0);
    check("R1 flag", {31'd0, div_zero_o}, 32'd0);
    check("R1 quotient", quotient_o, 32'd0);
    check("R1 remainder", remainder_o, 32'd0);
    rst = 1'b0;

    run(32'd100, 32'd7);
    run(32'hFFFF_FFFF, 32'd1);
    run(32'h1234_5678, 32'h1234_5678);
    run(32'd1, 32'd1);
    run(32'd0, 32'd5);
    run(32'd3, 32'd10);
    run(32'd5, 32'd0);
    run(32'd0, 32'd0);
    run(32'd77, 32'd4);
    run(32'h8000_0000, 32'hFFFF_FFFF);
    run(32'h8000_0000, 32'd3);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFE);

    // R7: second start while busy carries conflicting operands
    @(negedge clk);
    start_i = 1'b1; dividend_i = 32'd1000; divisor_i = 32'd3;
    @(negedge clk);
    dividend_i = 32'd7; divisor_i = 32'd0;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done_o) break;
      @(negedge clk);
    end
    check("R7 quotient", quotient_o, 32'd333);
    check("R7 flag", {31'd0, div_zero_o}, 32'd0);
    @(negedge clk);

    for (int n = 0; n < 300; n++) begin
      logic [31:0] a, b;
      a = $urandom >> ($urandom % 8);
      b = $urandom >> ($urandom % 32);
      if (n % 25 == 0) b = 0;
      run(a, b);
    end
    finish_run();
  end
endmodule